// File: doc/BRIEF.md
# Multichannel SPI Channel Transfer Controller

This block holds the per-channel control state of a SPI host with several independent channels. Each channel keeps a configuration word, three status flags (receive full, transmit empty, end of transfer), an enable bit, and a transmit and a receive holding register. Software reaches these through a strobe-based register port. The block decides, each time software touches a channel, whether a word may be exchanged. It then updates the flags, pulses transmit-empty and receive-full events, and drives one transmit and one receive DMA request line per channel.

Each channel owns a small mode-0 shift engine with its own clock, data-out, data-in and active-low select pins. The engine exchanges one word of the configured length, most significant bit first, and then reports completion. A global single-channel input gates the shifting. When that input is high, only channels with their force bit set move data. Other channels still complete their bookkeeping as if the word had gone out.

Top module: `mspi_xfer_ctrl`

## Requirements
- R1: After reset every channel reads configuration 0x060000, status 0b010 (only transmit-empty set), control 0, all select pins high and all DMA requests low. The status read format is bit 0 receive-full, bit 1 transmit-empty, bit 2 end-of-transfer.
- R2: A configuration write stores only its low 23 bits. In that word, bits 11:7 hold word length minus one, bits 13:12 the transfer mode (0 both directions, 1 receive only, 2 transmit only), bit 14 the transmit DMA enable, bit 15 the receive DMA enable, bit 19 turbo and bit 20 force. The illegal flag of a channel is high when the mode field is 3 or the length field is below 3.
- R3: A transfer attempt follows three triggers: a transmit write, which first clears transmit-empty; a receive read, which first clears receive-full; and the enable bit going from 0 to 1. A disabled channel never shifts and raises no event. Writes to the status and receive registers have no effect. Register select codes are 0 configuration, 1 status, 2 control, 3 transmit, 4 receive, with the channel number above them in the address.
- R4: An attempt stalls when receive-full is set, the mode is not 2 and turbo is off. It also stalls when transmit-empty is set and the mode is not 1. A stalled attempt moves no data and changes no flag.
- R5: A completed attempt clears the transmit register and sets end-of-transfer and transmit-empty. It also sets receive-full unless the mode is 2. End-of-transfer stays set until reset.
- R6: With single-channel mode on and force off, a non-stalled attempt shifts nothing and leaves the receive register unchanged, but its flags and events complete as in R5. With force on, the word is shifted.
- R7: The transmit DMA request is enable AND transmit-DMA-enable AND transmit-empty AND mode not 1. The receive DMA request is enable AND receive-DMA-enable AND receive-full AND mode not 2.
- R8: After every attempt on an enabled channel, a one-cycle receive-full event is raised when receive-full is set, the mode is not 2 and turbo is off. A one-cycle transmit-empty event is raised when transmit-empty is set and the mode is not 1.
- R9: While a channel's shifter is busy, new attempts wait. Flags and events take their new values in the cycle after the shifter reports done.
- R10: A shift sends exactly length bits, most significant first. It uses two clock cycles per bit with the select low, the serial clock low then high, and data-in sampled at the end of the high phase. The received bits land right-aligned in the receive register with the upper bits zero.
- R11: With turbo on, a set receive-full flag neither stalls a transmit write nor raises the receive-full event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| single_mode | input | 1 | Gate: only forced channels shift when high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (receive read has side effects) |
| reg_addr | input | CH_W+3 | {channel, register select} |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from address |
| cfg_bad | output | NUM_CH | Illegal configuration per channel |
| dma_tx_req | output | NUM_CH | Transmit DMA request per channel |
| dma_rx_req | output | NUM_CH | Receive DMA request per channel |
| evt_tx_empty | output | NUM_CH | One-cycle transmit-empty event |
| evt_rx_full | output | NUM_CH | One-cycle receive-full event |
| spi_sclk | output | NUM_CH | Serial clock per channel (idle low) |
| spi_mosi | output | NUM_CH | Serial data out per channel |
| spi_miso | input | NUM_CH | Serial data in per channel |
| spi_cs_n | output | NUM_CH | Active-low select, low while shifting |

## Verification
The assertions check four rules on every cycle. A shift never starts on a busy engine. The select releases right after done. End-of-transfer, once set, never clears. A finished transfer always leaves transmit-empty set, and in transmit-only mode it never sets receive-full. Only the bench scenarios can show the rest: the stall decisions, the single-channel and force gating, turbo, the event counts per trigger, the DMA request levels, and the bit-exact receive data across every legal word length with loopback, inverted and constant data-in.

// File: rtl/mspi_pkg.sv
package mspi_pkg;
   localparam int SEL_W        = 3;
   localparam int CONF_W       = 23;
   localparam int LEN_W        = 6;
   localparam int WL_MAX       = 32;
   localparam int WL_MIN_FIELD = 3;
   localparam int CF_WL_LO     = 7;
   localparam int CF_WL_HI     = 11;
   localparam int CF_TRM_LO    = 12;
   localparam int CF_TRM_HI    = 13;
   localparam int CF_DMA_TX    = 14;
   localparam int CF_DMA_RX    = 15;
   localparam int CF_TURBO     = 19;
   localparam int CF_FORCE     = 20;
   localparam logic [CONF_W-1:0] CONF_RST = 23'h060000;

   typedef enum logic [SEL_W-1:0] {
      SEL_CONF = 3'd0,
      SEL_STAT = 3'd1,
      SEL_CTRL = 3'd2,
      SEL_TX   = 3'd3,
      SEL_RX   = 3'd4
   } reg_sel_e;

   typedef enum logic [1:0] {
      XM_BOTH  = 2'd0,
      XM_RX    = 2'd1,
      XM_TX    = 2'd2,
      XM_ILLEG = 2'd3
   } xfer_mode_e;
endpackage

// File: rtl/mspi_shifter.sv
module mspi_shifter
   import mspi_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [LEN_W-1:0]  len,
   input  logic [DATA_W-1:0] tx_word,
   input  logic              miso,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rx_word,
   output logic              sclk,
   output logic              mosi,
   output logic              cs_n
);
   localparam int SH_W = $clog2(DATA_W + 1);

   logic              phase_q;
   logic [LEN_W-1:0]  left_q;
   logic [DATA_W-1:0] sreg_q;
   logic [DATA_W-1:0] rsh_q;
   logic [SH_W-1:0]   shamt;

   assign shamt   = SH_W'(DATA_W) - SH_W'(len);
   assign done    = busy && phase_q && (left_q == LEN_W'(1));
   assign rx_word = {rsh_q[DATA_W-2:0], miso};
   assign sclk    = busy && phase_q;
   assign mosi    = busy && sreg_q[DATA_W-1];
   assign cs_n    = !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         phase_q <= 1'b0;
         left_q  <= '0;
         sreg_q  <= '0;
         rsh_q   <= '0;
      end else if (start) begin
         busy    <= 1'b1;
         phase_q <= 1'b0;
         left_q  <= len;
         sreg_q  <= tx_word << shamt;
         rsh_q   <= '0;
      end else if (busy) begin
         if (!phase_q) begin
            phase_q <= 1'b1;
         end else begin
            phase_q <= 1'b0;
            sreg_q  <= sreg_q << 1;
            rsh_q   <= rx_word;
            left_q  <= left_q - LEN_W'(1);
            if (left_q == LEN_W'(1)) busy <= 1'b0;
         end
      end
   end

   AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy); // R9
   AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> cs_n); // R10
   AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (len != '0)); // R10
endmodule

// File: rtl/mspi_chan.sv
module mspi_chan
   import mspi_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              single_mode,
   input  logic              wr_conf,
   input  logic              wr_ctrl,
   input  logic              wr_tx,
   input  logic              rd_rx,
   input  logic [DATA_W-1:0] wdata,
   output logic [CONF_W-1:0] conf_q,
   output logic [2:0]        stat_q,
   output logic              en_q,
   output logic [DATA_W-1:0] tx_q,
   output logic [DATA_W-1:0] rx_q,
   output logic              cfg_bad,
   output logic              txdrq,
   output logic              rxdrq,
   output logic              evt_txe,
   output logic              evt_rxf,
   output logic              sh_start,
   output logic [LEN_W-1:0]  sh_len,
   input  logic              sh_busy,
   input  logic              sh_done,
   input  logic [DATA_W-1:0] sh_rx
);
   logic       rxs_q, txs_q, eot_q, pend_q;
   xfer_mode_e mode;
   logic       turbo, force_b;
   logic       eval, stall, go_shift, fin_now;

   assign mode    = xfer_mode_e'(conf_q[CF_TRM_HI:CF_TRM_LO]);
   assign turbo   = conf_q[CF_TURBO];
   assign force_b = conf_q[CF_FORCE];
   assign stat_q  = {eot_q, txs_q, rxs_q};
   assign sh_len  = LEN_W'(conf_q[CF_WL_HI:CF_WL_LO]) + LEN_W'(1);
   assign cfg_bad = (mode == XM_ILLEG) ||
                    (conf_q[CF_WL_HI:CF_WL_LO] < 5'(WL_MIN_FIELD));
   assign txdrq   = en_q && conf_q[CF_DMA_TX] && txs_q && (mode != XM_RX);
   assign rxdrq   = en_q && conf_q[CF_DMA_RX] && rxs_q && (mode != XM_TX);

   always_comb begin
      eval     = pend_q && !sh_busy;
      stall    = (rxs_q && (mode != XM_TX) && !turbo) ||
                 (txs_q && (mode != XM_RX));
      go_shift = !single_mode || force_b;
      sh_start = eval && en_q && !stall && go_shift;
      fin_now  = eval && en_q && !stall && !go_shift;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conf_q  <= CONF_RST;
         rxs_q   <= 1'b0;
         txs_q   <= 1'b1;
         eot_q   <= 1'b0;
         en_q    <= 1'b0;
         pend_q  <= 1'b0;
         tx_q    <= '0;
         rx_q    <= '0;
         evt_txe <= 1'b0;
         evt_rxf <= 1'b0;
      end else begin
         evt_txe <= 1'b0;
         evt_rxf <= 1'b0;
         if (eval) pend_q <= 1'b0;
         if (eval && en_q && stall) begin
            evt_rxf <= rxs_q && (mode != XM_TX) && !turbo;
            evt_txe <= txs_q && (mode != XM_RX);
         end
         if (fin_now || sh_done) begin
            tx_q    <= '0;
            eot_q   <= 1'b1;
            txs_q   <= 1'b1;
            if (mode != XM_TX) rxs_q <= 1'b1;
            evt_rxf <= (mode != XM_TX) && !turbo;
            evt_txe <= (mode != XM_RX);
         end
         if (sh_done) rx_q <= sh_rx;
         if (wr_conf) conf_q <= wdata[CONF_W-1:0];
         if (wr_ctrl) begin
            if (wdata[0] && !en_q) pend_q <= 1'b1;
            en_q <= wdata[0];
         end
         if (wr_tx) begin
            tx_q   <= wdata;
            txs_q  <= 1'b0;
            pend_q <= 1'b1;
         end
         if (rd_rx) begin
            rxs_q  <= 1'b0;
            pend_q <= 1'b1;
         end
      end
   end

   AST_FLAGS_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_done && !wr_tx) |=> (txs_q && eot_q)); // R9
   AST_TXONLY_NO_RXS: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_done && (mode == XM_TX) && !rxs_q) |=> !rxs_q); // R5
   AST_EOT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      eot_q |=> eot_q); // R5
endmodule

// File: rtl/mspi_xfer_ctrl.sv
module mspi_xfer_ctrl
   import mspi_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int DATA_W = 32,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int ADDR_W = CH_W + SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              single_mode,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [NUM_CH-1:0] cfg_bad,
   output logic [NUM_CH-1:0] dma_tx_req,
   output logic [NUM_CH-1:0] dma_rx_req,
   output logic [NUM_CH-1:0] evt_tx_empty,
   output logic [NUM_CH-1:0] evt_rx_full,
   output logic [NUM_CH-1:0] spi_sclk,
   output logic [NUM_CH-1:0] spi_mosi,
   input  logic [NUM_CH-1:0] spi_miso,
   output logic [NUM_CH-1:0] spi_cs_n
);
   if (NUM_CH < 2) begin : g_bad_ch
      $error("NUM_CH must be at least 2");
   end
   if (DATA_W < WL_MAX) begin : g_bad_w
      $error("DATA_W must hold the longest word");
   end

   logic [CH_W-1:0] ch_sel;
   reg_sel_e        sel;
   logic [CONF_W-1:0] conf_a [NUM_CH];
   logic [2:0]        stat_a [NUM_CH];
   logic              en_a   [NUM_CH];
   logic [DATA_W-1:0] tx_a   [NUM_CH];
   logic [DATA_W-1:0] rx_a   [NUM_CH];

   assign ch_sel = reg_addr[ADDR_W-1:SEL_W];
   assign sel    = reg_sel_e'(reg_addr[SEL_W-1:0]);

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic              hit;
      logic              sh_start, sh_busy, sh_done;
      logic [LEN_W-1:0]  sh_len;
      logic [DATA_W-1:0] sh_rx;

      assign hit = (ch_sel == CH_W'(g));

      mspi_chan #(.DATA_W(DATA_W)) chan_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .single_mode(single_mode),
         .wr_conf    (reg_wr && hit && (sel == SEL_CONF)),
         .wr_ctrl    (reg_wr && hit && (sel == SEL_CTRL)),
         .wr_tx      (reg_wr && hit && (sel == SEL_TX)),
         .rd_rx      (reg_rd && hit && (sel == SEL_RX)),
         .wdata      (reg_wdata),
         .conf_q     (conf_a[g]),
         .stat_q     (stat_a[g]),
         .en_q       (en_a[g]),
         .tx_q       (tx_a[g]),
         .rx_q       (rx_a[g]),
         .cfg_bad    (cfg_bad[g]),
         .txdrq      (dma_tx_req[g]),
         .rxdrq      (dma_rx_req[g]),
         .evt_txe    (evt_tx_empty[g]),
         .evt_rxf    (evt_rx_full[g]),
         .sh_start   (sh_start),
         .sh_len     (sh_len),
         .sh_busy    (sh_busy),
         .sh_done    (sh_done),
         .sh_rx      (sh_rx)
      );

      mspi_shifter #(.DATA_W(DATA_W)) shf_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .start  (sh_start),
         .len    (sh_len),
         .tx_word(tx_a[g]),
         .miso   (spi_miso[g]),
         .busy   (sh_busy),
         .done   (sh_done),
         .rx_word(sh_rx),
         .sclk   (spi_sclk[g]),
         .mosi   (spi_mosi[g]),
         .cs_n   (spi_cs_n[g])
      );
   end

   always_comb begin
      reg_rdata = '0;
      if (int'(ch_sel) < NUM_CH) begin
         case (sel)
            SEL_CONF: reg_rdata = DATA_W'(conf_a[ch_sel]);
            SEL_STAT: reg_rdata = DATA_W'(stat_a[ch_sel]);
            SEL_CTRL: reg_rdata = DATA_W'(en_a[ch_sel]);
            SEL_TX:   reg_rdata = tx_a[ch_sel];
            SEL_RX:   reg_rdata = rx_a[ch_sel];
            default:  reg_rdata = '0;
         endcase
      end
   end
endmodule

// File: tb/mspi_xfer_ctrl_tb_top.sv
module mspi_xfer_ctrl_tb_top;
   localparam int NCH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        single_mode = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [NCH-1:0] cfg_bad, dma_tx_req, dma_rx_req, evt_tx_empty, evt_rx_full;
   logic [NCH-1:0] spi_sclk, spi_mosi, spi_miso, spi_cs_n;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;
   int txe_cnt [NCH];
   int rxf_cnt [NCH];
   int bit_cnt [NCH];

   always #5 clk = ~clk;

   // ch0 and ch3 loop back, ch1 inverts, ch2 reads all ones
   assign spi_miso = {spi_mosi[3], 1'b1, ~spi_mosi[1], spi_mosi[0]};

   mspi_xfer_ctrl #(.NUM_CH(NCH), .DATA_W(32)) dut_i (
      .clk(clk), .rst_n(rst_n), .single_mode(single_mode),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_bad(cfg_bad),
      .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req),
      .evt_tx_empty(evt_tx_empty), .evt_rx_full(evt_rx_full),
      .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
      .spi_cs_n(spi_cs_n)
   );

   always @(negedge clk) begin
      for (int i = 0; i < NCH; i++) begin
         if (evt_tx_empty[i]) txe_cnt[i]++;
         if (evt_rx_full[i])  rxf_cnt[i]++;
         if (spi_sclk[i])     bit_cnt[i]++;
      end
   end

   localparam logic [2:0] S_CONF = 3'd0, S_STAT = 3'd1, S_CTRL = 3'd2,
                          S_TX = 3'd3, S_RX = 3'd4;

   function automatic logic [31:0] mask(int n);
      return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
   endfunction

   function automatic logic [31:0] cfg(int len, int mode, bit dtx, bit drx,
                                       bit turbo, bit frc);
      logic [31:0] v;
      v = 32'((len - 1) & 31) << 7;
      v = v | (32'(mode & 3) << 12);
      v = v | (32'(dtx) << 14) | (32'(drx) << 15);
      v = v | (32'(turbo) << 19) | (32'(frc) << 20);
      return v;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(int ch, logic [2:0] sel, logic [31:0] d);
      @(negedge clk);
      reg_addr = {2'(ch), sel};
      reg_wdata = d;
      reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(int ch, logic [2:0] sel, output logic [31:0] d);
      @(negedge clk);
      reg_addr = {2'(ch), sel};
      reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic clr_cnt();
      for (int i = 0; i < NCH; i++) begin
         txe_cnt[i] = 0; rxf_cnt[i] = 0; bit_cnt[i] = 0;
      end
   endtask

   task automatic settle();
      repeat (80) @(negedge clk);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic [31:0] d, dat, exp;
      clr_cnt();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int c = 0; c < NCH; c++) begin
         rd(c, S_CONF, d); chk("R1 conf", d, 32'h060000);
         rd(c, S_STAT, d); chk("R1 stat", d, 32'h2);
         rd(c, S_CTRL, d); chk("R1 ctrl", d, 32'h0);
      end
      chk("R1 dma", {28'd0, dma_tx_req | dma_rx_req}, 32'h0);
      chk("R1 cs_n", {28'd0, spi_cs_n}, 32'hF);
      chk("R2 reset length illegal", {28'd0, cfg_bad}, 32'hF);

      // ch0: 8-bit, both directions, both DMA enables
      wr(0, S_CONF, cfg(8, 0, 1, 1, 0, 0));
      chk("R2 legal conf", {31'd0, cfg_bad[0]}, 32'h0);
      clr_cnt();
      wr(0, S_CTRL, 32'h1);
      settle();
      chk("R3 R4 enable stalls on TXS", 32'(bit_cnt[0]), 32'd0);
      chk("R8 enable tx-empty event", 32'(txe_cnt[0]), 32'd1);
      chk("R8 no rx-full event", 32'(rxf_cnt[0]), 32'd0);
      chk("R7 tx dma", {31'd0, dma_tx_req[0]}, 32'h1);
      chk("R7 rx dma", {31'd0, dma_rx_req[0]}, 32'h0);

      // R10 first transfer
      clr_cnt();
      wr(0, S_TX, 32'hA5);
      repeat (3) @(negedge clk);
      chk("R10 cs low while shifting", {31'd0, spi_cs_n[0]}, 32'h0);
      chk("R7 tx dma drops", {31'd0, dma_tx_req[0]}, 32'h0);
      settle();
      chk("R10 bit count", 32'(bit_cnt[0]), 32'd8);
      rd(0, S_STAT, d); chk("R5 status after shift", d, 32'h7);
      chk("R8 events after shift", {rxf_cnt[0][15:0], txe_cnt[0][15:0]}, 32'h0001_0001);
      chk("R7 both dma", {30'd0, dma_rx_req[0], dma_tx_req[0]}, 32'h3);
      rd(0, S_TX, d); chk("R5 tx cleared", d, 32'h0);
      rd(0, S_RX, d); chk("R10 loopback", d, 32'hA5);
      settle();

      // R4 stall on receive-full
      wr(0, S_TX, 32'h3C);
      settle();
      clr_cnt();
      wr(0, S_TX, 32'h11);
      settle();
      chk("R4 stall no shift", 32'(bit_cnt[0]), 32'd0);
      chk("R8 stall rx-full event", {rxf_cnt[0][15:0], txe_cnt[0][15:0]}, 32'h0001_0000);
      rd(0, S_STAT, d); chk("R4 stall flags", d, 32'h5);
      rd(0, S_RX, d); chk("R3 rx read value", d, 32'h3C);
      settle();
      chk("R3 rx read restarts", 32'(bit_cnt[0]), 32'd8);
      rd(0, S_RX, d); chk("R10 second word", d, 32'h11);
      settle();

      // R10 sweep of every legal length on three data-in patterns
      wr(1, S_CTRL, 32'h1);
      wr(2, S_CTRL, 32'h1);
      settle();
      for (int n = 4; n <= 32; n++) begin
         dat = 32'h9E37_79B9 * 32'(n);
         for (int c = 0; c < 3; c++) begin
            wr(c, S_CONF, cfg(n, 0, 0, 0, 0, 0));
            clr_cnt();
            wr(c, S_TX, dat);
            settle();
            chk("R10 sweep bits", 32'(bit_cnt[c]), 32'(n));
            exp = (c == 0) ? (dat & mask(n)) :
                  (c == 1) ? (~dat & mask(n)) : mask(n);
            rd(c, S_RX, d);
            chk("R10 sweep data", d, exp);
         end
      end
      settle();

      // R11 turbo on ch3
      wr(3, S_CONF, cfg(16, 0, 0, 0, 1, 0));
      wr(3, S_CTRL, 32'h1);
      settle();
      wr(3, S_TX, 32'h1234);
      settle();
      clr_cnt();
      wr(3, S_TX, 32'hBEEF);
      settle();
      chk("R11 turbo shifts", 32'(bit_cnt[3]), 32'd16);
      chk("R11 turbo events", {rxf_cnt[3][15:0], txe_cnt[3][15:0]}, 32'h0000_0001);
      rd(3, S_RX, d); chk("R11 turbo data", d, 32'hBEEF);
      settle();

      // R5 R7 transmit-only
      wr(3, S_CONF, cfg(8, 2, 1, 1, 0, 0));
      clr_cnt();
      wr(3, S_TX, 32'h5A);
      settle();
      chk("R5 tx-only bits", 32'(bit_cnt[3]), 32'd8);
      rd(3, S_STAT, d); chk("R5 tx-only no RXS", d, 32'h6);
      chk("R7 tx-only rx dma", {30'd0, dma_rx_req[3], dma_tx_req[3]}, 32'h1);
      chk("R8 tx-only events", {rxf_cnt[3][15:0], txe_cnt[3][15:0]}, 32'h0000_0001);

      // receive-only: enable alone launches a shift
      wr(3, S_CTRL, 32'h0);
      wr(3, S_CONF, cfg(8, 1, 1, 1, 0, 0));
      clr_cnt();
      wr(3, S_CTRL, 32'h1);
      settle();
      chk("R3 rx-only enable shifts", 32'(bit_cnt[3]), 32'd8);
      rd(3, S_STAT, d); chk("R5 rx-only status", d, 32'h7);
      chk("R7 rx-only dma", {30'd0, dma_rx_req[3], dma_tx_req[3]}, 32'h2);
      chk("R8 rx-only events", {rxf_cnt[3][15:0], txe_cnt[3][15:0]}, 32'h0001_0000);
      rd(3, S_RX, d); chk("R10 rx-only zero word", d, 32'h0);
      settle();
      chk("R3 rx-only read reshifts", 32'(bit_cnt[3]), 32'd16);

      // R6 single-channel gate on ch0 (last rx = sweep word n=32)
      dat = 32'h9E37_79B9 * 32'd32;
      single_mode = 1'b1;
      wr(0, S_CONF, cfg(8, 0, 0, 0, 0, 0));
      clr_cnt();
      wr(0, S_TX, 32'h77);
      settle();
      chk("R6 gated no shift", 32'(bit_cnt[0]), 32'd0);
      rd(0, S_STAT, d); chk("R6 gated flags", d, 32'h7);
      rd(0, S_TX, d); chk("R6 gated tx cleared", d, 32'h0);
      chk("R6 gated events", {rxf_cnt[0][15:0], txe_cnt[0][15:0]}, 32'h0001_0001);
      rd(0, S_RX, d); chk("R6 gated rx unchanged", d, dat);
      wr(0, S_CONF, cfg(8, 0, 0, 0, 0, 1));
      settle();
      clr_cnt();
      wr(0, S_TX, 32'h66);
      settle();
      chk("R6 forced shift", 32'(bit_cnt[0]), 32'd8);
      rd(0, S_RX, d); chk("R6 forced data", d, 32'h66);
      single_mode = 1'b0;
      settle();

      // R9 write during busy waits and is then overwritten by completion
      clr_cnt();
      wr(0, S_TX, 32'h01);
      repeat (3) @(negedge clk);
      wr(0, S_TX, 32'h02);
      settle();
      chk("R9 held off", 32'(bit_cnt[0]), 32'd8);
      rd(0, S_RX, d); chk("R9 first word", d, 32'h01);
      settle();

      // R3 disabled channel and read-only registers
      wr(2, S_CTRL, 32'h0);
      clr_cnt();
      wr(2, S_TX, 32'h99);
      settle();
      chk("R3 disabled no shift", 32'(bit_cnt[2]), 32'd0);
      chk("R3 disabled no events", 32'(txe_cnt[2] + rxf_cnt[2]), 32'd0);
      rd(2, S_STAT, d); chk("R3 disabled flags", d, 32'h4);
      wr(2, S_STAT, 32'h7);
      rd(2, S_STAT, d); chk("R3 status write ignored", d, 32'h4);
      rd(2, S_RX, d); exp = d;
      wr(2, S_RX, 32'h1234_5678);
      rd(2, S_RX, d); chk("R3 rx write ignored", d, exp);

      // R2 configuration storage and illegal flag
      wr(2, S_CONF, cfg(8, 3, 0, 0, 0, 0));
      chk("R2 mode 3 illegal", {31'd0, cfg_bad[2]}, 32'h1);
      wr(2, S_CONF, cfg(3, 0, 0, 0, 0, 0));
      chk("R2 length field 2 illegal", {31'd0, cfg_bad[2]}, 32'h1);
      wr(2, S_CONF, cfg(4, 0, 0, 0, 0, 0));
      chk("R2 length field 3 legal", {31'd0, cfg_bad[2]}, 32'h0);
      wr(2, S_CONF, 32'hFFFF_FFFF);
      rd(2, S_CONF, d); chk("R2 23-bit store", d, 32'h7F_FFFF);

      summary();
   end
endmodule